// File: doc/BRIEF.md
# Vector Register Execution Unit

This block is an in-order vector unit that owns a file of vector registers and one scalar register. A command carries an opcode, a destination register, two source registers and a byte base address. Once a command is accepted, the unit runs the same operation over every element of a vector, issuing one element per clock. Each element goes through a short arithmetic pipeline and is then written back into the register file. Integer arithmetic, wrapping at 64 bits, stands in for floating point.

Vector loads and stores move a whole vector over a single-word memory port. Element k uses the address base + 8k. Any command issued while busy is high is refused, so hazards are only considered when a command starts. A vector element never has to wait for another element of the same command. A memory element waits only while the port withholds ready. A scaled-vector-plus-vector kernel takes exactly six commands: scalar load, vector load, vector-times-scalar, vector load, vector add, vector store.

The sequencer has three states:
- ST_IDLE: waiting for a command.
- ST_ISSUE: one element is sent per cycle.
- ST_DRAIN: in-flight results are being written back.

It has four transitions:
- start: ST_IDLE to ST_ISSUE, on a legal command.
- last-store: ST_ISSUE to ST_IDLE, when the final store element transfers.
- last-element: ST_ISSUE to ST_DRAIN, for all other operations after the final element issues.
- empty: ST_DRAIN to ST_IDLE, once no result remains in flight.

Top module: `vec_exec_unit`

## Requirements
- R1: While reset is asserted and after reset is released, busy and mem_valid are low and cmd_ready is high.
- R2: A command is taken when cmd_valid and cmd_ready are both high at a clock edge. cmd_ready is low whenever busy is high. A command offered while busy has no effect. busy rises in the cycle after a legal command is taken.
- R3: A vector load (opcode 3) reads 64 words at addresses base, base+8, and so on up to base+504. It places word k into element k of register cmd_dst.
- R4: A vector store (opcode 4) writes element k of register cmd_srca to address base+8k for k = 0..63, with mem_write high. Without stalls, busy stays high for exactly 64 cycles.
- R5: While mem_valid is high and mem_ready is low, the request holds its address, write flag and write data, and element issue pauses. Each element transfers exactly once, in ascending order.
- R6: Vector-vector add (opcode 0) sets element k of cmd_dst to srca[k] + srcb[k] modulo 2^64.
- R7: Vector-scalar add (opcode 1) sets element k of cmd_dst to srca[k] + scalar modulo 2^64.
- R8: Vector-scalar multiply (opcode 2) sets element k of cmd_dst to the low 64 bits of srca[k] * scalar.
- R9: Scalar load (opcode 5) reads one word at base into the scalar register. It makes exactly one memory transfer and keeps busy high for 2 cycles.
- R10: Without stalls, busy stays high for 65 cycles for an add or a vector load and 67 cycles for a multiply. Arithmetic commands make no memory transfers.
- R11: Opcodes 6 and 7 are taken but leave busy low and all registers unchanged.
- R12: The six-command sequence of scalar load, load X, multiply, load Y, add and store Y leaves Y[k] = a*X[k] + Y[k] modulo 2^64 in memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command is offered |
| cmd_ready | output | 1 | The unit can take a command |
| cmd_op | input | 3 | Opcode (encodings in R3 to R11) |
| cmd_dst | input | 3 | Destination vector register |
| cmd_srca | input | 3 | First source vector register (store data source) |
| cmd_srcb | input | 3 | Second source vector register |
| cmd_base | input | 32 | Byte base address for memory commands |
| busy | output | 1 | A command is in progress |
| mem_valid | output | 1 | Memory request valid |
| mem_write | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the request |
| mem_wdata | output | 64 | Write data |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rdata | input | 64 | Read data, valid in the accepting cycle |

## Verification
The hardest case to reach from the ports is a memory stall on the very first element of a load or store, together with later stalls that hit the middle of the stream. The bench drives mem_ready from periodic patterns whose low phases line up with command starts and cut the stream at irregular points. It logs every handshake address and compares it against base+8k. A second hard case is a command offered while a multiply is still running. The bench offers a scalar load from a poisoned address during the first cycles of a multiply. It then proves the scalar was untouched through a later vector-scalar add that is stored and compared.

// File: rtl/vxu_pkg.sv
package vxu_pkg;

    typedef logic [2:0] vop_t;

    localparam vop_t OP_ADDVV  = 3'd0;
    localparam vop_t OP_ADDVS  = 3'd1;
    localparam vop_t OP_MULVS  = 3'd2;
    localparam vop_t OP_LOADV  = 3'd3;
    localparam vop_t OP_STOREV = 3'd4;
    localparam vop_t OP_LOADS  = 3'd5;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_DRAIN = 2'd2
    } vseq_state_e;

    function automatic logic op_legal(input vop_t op);
        return op <= OP_LOADS;
    endfunction

    function automatic logic op_is_mem(input vop_t op);
        return (op == OP_LOADV) || (op == OP_STOREV) || (op == OP_LOADS);
    endfunction

    function automatic logic op_uses_add(input vop_t op);
        return (op == OP_ADDVV) || (op == OP_ADDVS) ||
               (op == OP_LOADV) || (op == OP_LOADS);
    endfunction

endpackage

// File: rtl/vxu_vrf.sv
module vxu_vrf #(
    parameter int NREGS = 8,
    parameter int VLEN  = 64,
    parameter int EW    = 64,
    localparam int RW   = $clog2(NREGS),
    localparam int IW   = $clog2(VLEN)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [RW-1:0] wr_reg,
    input  logic [IW-1:0] wr_idx,
    input  logic [EW-1:0] wr_data,
    input  logic [RW-1:0] ra_reg,
    input  logic [RW-1:0] rb_reg,
    input  logic [IW-1:0] rd_idx,
    output logic [EW-1:0] ra_data,
    output logic [EW-1:0] rb_data
);

    localparam int CELLS = NREGS * VLEN;

    // One flat array; register number forms the upper address bits.
    logic [EW-1:0] cell_q [CELLS];

    always_ff @(posedge clk) begin
        if (we) begin
            cell_q[{wr_reg, wr_idx}] <= wr_data;
        end
    end

    assign ra_data = cell_q[{ra_reg, rd_idx}];
    assign rb_data = cell_q[{rb_reg, rd_idx}];

endmodule

// File: rtl/vxu_pipe.sv
module vxu_pipe #(
    parameter int DEPTH = 1,
    parameter int IW    = 6,
    parameter int DW    = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [IW-1:0] in_idx,
    input  logic [DW-1:0] in_data,
    output logic          out_valid,
    output logic [IW-1:0] out_idx,
    output logic [DW-1:0] out_data,
    output logic          pending
);

    logic [DEPTH-1:0] vld_q;
    logic [IW-1:0]    idx_q [DEPTH];
    logic [DW-1:0]    dat_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            vld_q[0] <= in_valid;
            for (int s = 1; s < DEPTH; s++) begin
                vld_q[s] <= vld_q[s-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        idx_q[0] <= in_idx;
        dat_q[0] <= in_data;
        for (int s = 1; s < DEPTH; s++) begin
            idx_q[s] <= idx_q[s-1];
            dat_q[s] <= dat_q[s-1];
        end
    end

    // pending: an element will still be in flight after the next edge.
    if (DEPTH > 1) begin : g_deep
        assign pending = |vld_q[DEPTH-2:0];
    end else begin : g_single
        assign pending = 1'b0;
    end

    assign out_valid = vld_q[DEPTH-1];
    assign out_idx   = idx_q[DEPTH-1];
    assign out_data  = dat_q[DEPTH-1];

endmodule

// File: rtl/vxu_seq.sv
module vxu_seq
    import vxu_pkg::*;
#(
    parameter int VLEN = 64,
    localparam int IW  = $clog2(VLEN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  vop_t          cmd_op,
    input  logic          mem_ready,
    input  logic          add_pending,
    input  logic          mul_pending,
    output logic          cmd_ready,
    output logic          start,
    output logic          busy,
    output logic          fire,
    output logic          mem_valid,
    output vop_t          op,
    output logic [IW-1:0] idx
);

    localparam logic [IW-1:0] LAST_IDX = IW'(VLEN - 1);

    vseq_state_e   state_q, state_d;
    vop_t          op_q;
    logic [IW-1:0] idx_q;
    logic          last_elem;

    assign last_elem = (op_q == OP_LOADS) || (idx_q == LAST_IDX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin : next_state
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = ST_ISSUE;
            end
            ST_ISSUE: begin
                if (fire && last_elem) begin
                    state_d = (op_q == OP_STOREV) ? ST_IDLE : ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (!add_pending && !mul_pending) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin : seq_outputs
        cmd_ready = 1'b0;
        busy      = 1'b0;
        mem_valid = 1'b0;
        fire      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                cmd_ready = 1'b1;
            end
            ST_ISSUE: begin
                busy      = 1'b1;
                mem_valid = op_is_mem(op_q);
                fire      = !op_is_mem(op_q) || mem_ready;
            end
            ST_DRAIN: begin
                busy = 1'b1;
            end
            default: ;
        endcase
        start = cmd_ready && cmd_valid && op_legal(cmd_op);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q  <= OP_ADDVV;
            idx_q <= '0;
        end else if (start) begin
            op_q  <= cmd_op;
            idx_q <= '0;
        end else if (fire) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    assign op  = op_q;
    assign idx = idx_q;

endmodule

// File: rtl/vec_exec_unit.sv
module vec_exec_unit
    import vxu_pkg::*;
#(
    parameter int NREGS      = 8,
    parameter int VLEN       = 64,
    parameter int EW         = 64,
    parameter int AW         = 32,
    parameter int MUL_STAGES = 3,
    parameter int ADD_STAGES = 1,
    localparam int RW        = $clog2(NREGS),
    localparam int IW        = $clog2(VLEN),
    localparam int BSH       = $clog2(EW / 8)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic [2:0]    cmd_op,
    input  logic [RW-1:0] cmd_dst,
    input  logic [RW-1:0] cmd_srca,
    input  logic [RW-1:0] cmd_srcb,
    input  logic [AW-1:0] cmd_base,
    output logic          busy,
    output logic          mem_valid,
    output logic          mem_write,
    output logic [AW-1:0] mem_addr,
    output logic [EW-1:0] mem_wdata,
    input  logic          mem_ready,
    input  logic [EW-1:0] mem_rdata
);

    vop_t          op;
    logic [IW-1:0] idx;
    logic          start, fire;
    logic          add_pending, mul_pending;

    logic [RW-1:0] dst_q, srca_q, srcb_q;
    logic [AW-1:0] base_q;
    logic [EW-1:0] scalar_q;

    logic [EW-1:0] ra_data, rb_data, opnd_b;
    logic          add_in_valid, mul_in_valid;
    logic [EW-1:0] add_in_data, mul_in_data;
    logic          add_out_valid, mul_out_valid;
    logic [IW-1:0] add_out_idx, mul_out_idx;
    logic [EW-1:0] add_out_data, mul_out_data;
    logic          wb_valid, vrf_we;
    logic [IW-1:0] wb_idx;
    logic [EW-1:0] wb_data;

    vxu_seq #(.VLEN(VLEN)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_op      (cmd_op),
        .mem_ready   (mem_ready),
        .add_pending (add_pending),
        .mul_pending (mul_pending),
        .cmd_ready   (cmd_ready),
        .start       (start),
        .busy        (busy),
        .fire        (fire),
        .mem_valid   (mem_valid),
        .op          (op),
        .idx         (idx)
    );

    // Command fields are captured once, at start.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dst_q  <= '0;
            srca_q <= '0;
            srcb_q <= '0;
            base_q <= '0;
        end else if (start) begin
            dst_q  <= cmd_dst;
            srca_q <= cmd_srca;
            srcb_q <= cmd_srcb;
            base_q <= cmd_base;
        end
    end

    vxu_vrf #(.NREGS(NREGS), .VLEN(VLEN), .EW(EW)) u_vrf (
        .clk     (clk),
        .we      (vrf_we),
        .wr_reg  (dst_q),
        .wr_idx  (wb_idx),
        .wr_data (wb_data),
        .ra_reg  (srca_q),
        .rb_reg  (srcb_q),
        .rd_idx  (idx),
        .ra_data (ra_data),
        .rb_data (rb_data)
    );

    assign opnd_b       = (op == OP_ADDVV) ? rb_data : scalar_q;
    assign add_in_valid = fire && op_uses_add(op);
    assign add_in_data  = ((op == OP_LOADV) || (op == OP_LOADS)) ? mem_rdata
                                                                : ra_data + opnd_b;
    assign mul_in_valid = fire && (op == OP_MULVS);
    assign mul_in_data  = ra_data * scalar_q;

    vxu_pipe #(.DEPTH(ADD_STAGES), .IW(IW), .DW(EW)) u_add_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (add_in_valid),
        .in_idx    (idx),
        .in_data   (add_in_data),
        .out_valid (add_out_valid),
        .out_idx   (add_out_idx),
        .out_data  (add_out_data),
        .pending   (add_pending)
    );

    vxu_pipe #(.DEPTH(MUL_STAGES), .IW(IW), .DW(EW)) u_mul_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (mul_in_valid),
        .in_idx    (idx),
        .in_data   (mul_in_data),
        .out_valid (mul_out_valid),
        .out_idx   (mul_out_idx),
        .out_data  (mul_out_data),
        .pending   (mul_pending)
    );

    // Only one command runs at a time, so at most one pipe delivers.
    assign wb_valid = add_out_valid || mul_out_valid;
    assign wb_idx   = mul_out_valid ? mul_out_idx  : add_out_idx;
    assign wb_data  = mul_out_valid ? mul_out_data : add_out_data;
    assign vrf_we   = wb_valid && (op != OP_LOADS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scalar_q <= '0;
        end else if (add_out_valid && (op == OP_LOADS)) begin
            scalar_q <= add_out_data;
        end
    end

    assign mem_write = (op == OP_STOREV);
    assign mem_addr  = base_q + (AW'(idx) << BSH);
    assign mem_wdata = ra_data;

endmodule

// File: rtl/vec_exec_unit_chk.sv
module vec_exec_unit_chk #(
    parameter int AW = 32,
    parameter int EW = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic          cmd_ready,
    input logic [2:0]    cmd_op,
    input logic          busy,
    input logic          mem_valid,
    input logic          mem_write,
    input logic [AW-1:0] mem_addr,
    input logic [EW-1:0] mem_wdata,
    input logic          mem_ready
);

    localparam logic [AW-1:0] STEP = AW'(EW / 8);

    logic hs;
    assign hs = mem_valid && mem_ready;

    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && (cmd_op <= 3'd5)) |=> busy);

    p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hs && $past(hs)) |-> (mem_addr == $past(mem_addr) + STEP));

    p_stall_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=>
            (mem_valid && $stable(mem_addr) && $stable(mem_write) && $stable(mem_wdata)));

    p_illegal_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && (cmd_op > 3'd5)) |=> !busy);

endmodule

bind vec_exec_unit vec_exec_unit_chk #(.AW(AW), .EW(EW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_op    (cmd_op),
    .busy      (busy),
    .mem_valid (mem_valid),
    .mem_write (mem_write),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ready (mem_ready)
);

// File: tb/sim_vec_exec_unit.sv
`timescale 1ns/1ps
module sim_vec_exec_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [2:0]  cmd_op = '0, cmd_dst = '0, cmd_srca = '0, cmd_srcb = '0;
    logic [31:0] cmd_base = '0;
    logic        busy, mem_valid, mem_write;
    logic [31:0] mem_addr;
    logic [63:0] mem_wdata, mem_rdata;
    logic        mem_ready = 1'b1;

    logic [63:0] mem [0:1023];
    logic [31:0] hs_addr [0:2047];
    logic        hs_we   [0:2047];
    int          hs_n = 0;
    int          cyc = 0;
    int          ready_mode = 0;
    int          n_checks = 0;
    int          n_fail = 0;

    localparam logic [63:0] A_VAL = 64'hFFFF_FFFF_0000_0007;

    always #2 clk = ~clk;

    vec_exec_unit u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_dst(cmd_dst), .cmd_srca(cmd_srca), .cmd_srcb(cmd_srcb),
        .cmd_base(cmd_base), .busy(busy), .mem_valid(mem_valid), .mem_write(mem_write),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
        .mem_rdata(mem_rdata)
    );

    assign mem_rdata = mem[mem_addr[12:3]];

    // Memory model: pick ready for the next edge, then log the handshake
    // that edge will complete.
    always @(negedge clk) begin
        cyc++;
        case (ready_mode)
            0:       mem_ready = 1'b1;
            1:       mem_ready = (cyc % 6) >= 3;
            default: mem_ready = (cyc % 4) != 1;
        endcase
        if (rst_n && mem_valid && mem_ready) begin
            hs_addr[hs_n] = mem_addr;
            hs_we[hs_n]   = mem_write;
            if (mem_write) mem[mem_addr[12:3]] = mem_wdata;
            hs_n++;
        end
    end

    function automatic logic [63:0] xv(input int i);
        return 64'hF000_0000_0000_0000 + 64'(i) * 64'h0123_4567_89AB_CDEF;
    endfunction

    function automatic logic [63:0] yv(input int i);
        return 64'h9000_0000_0000_0001 ^ (64'(i) * 64'h1111_1111_1111_1111);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run(input logic [2:0] op, input int dst, input int sa, input int sb,
                       input logic [31:0] base, input int mode, input int exp_busy,
                       input bit poke, input string tag);
        int n, h0, nexp, bad;
        bit poke_ok;
        @(negedge clk);
        ready_mode = mode;
        chk(cmd_ready == 1'b1, "R2 ready when idle", 64'(cmd_ready), 64'd1);
        cmd_op = op; cmd_dst = dst[2:0]; cmd_srca = sa[2:0]; cmd_srcb = sb[2:0];
        cmd_base = base; cmd_valid = 1'b1;
        h0 = hs_n;
        @(negedge clk);
        cmd_valid = 1'b0;
        n = 0; poke_ok = 1'b1;
        while (busy && n < 5000) begin
            if (poke && n < 10) begin
                // Poisoned scalar load offered while busy (R2).
                cmd_op = 3'd5; cmd_base = 32'h0000_0C00; cmd_valid = 1'b1;
                if (cmd_ready) poke_ok = 1'b0;
            end else begin
                cmd_valid = 1'b0;
            end
            n++;
            @(negedge clk);
        end
        cmd_valid = 1'b0;
        if (poke) chk(poke_ok, "R2 refused while busy", 64'(poke_ok), 64'd1);
        if (exp_busy >= 0) chk(n == exp_busy, {tag, " busy cycles"}, 64'(n), 64'(exp_busy));
        nexp = (op == 3'd3 || op == 3'd4) ? 64 : (op == 3'd5) ? 1 : 0;
        chk((hs_n - h0) == nexp, {tag, " transfer count"}, 64'(hs_n - h0), 64'(nexp));
        bad = 0;
        for (int k = 0; k < nexp && (h0 + k) < hs_n; k++) begin
            if (hs_addr[h0+k] != base + 32'(8*k) || hs_we[h0+k] != (op == 3'd4)) bad++;
        end
        chk(bad == 0, {tag, " address sequence"}, 64'(bad), 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R2 actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        for (int i = 0; i < 64; i++) begin
            mem[i]      = xv(i);
            mem[64 + i] = yv(i);
        end
        mem[192] = A_VAL;
        mem[384] = 64'h5555_AAAA_5555_AAAA;

        repeat (4) @(negedge clk);
        chk(busy == 1'b0 && mem_valid == 1'b0, "R1 in reset", {62'd0, busy, mem_valid}, 64'd0);
        chk(cmd_ready == 1'b1, "R1 ready in reset", 64'(cmd_ready), 64'd1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0 && mem_valid == 1'b0, "R1 after reset", {62'd0, busy, mem_valid}, 64'd0);

        // Six-command kernel (R12).
        run(3'd5, 0, 0, 0, 32'h0000_0600, 0, 2,  1'b0, "R9");
        run(3'd3, 1, 0, 0, 32'h0000_0000, 1, -1, 1'b0, "R3/R5");
        run(3'd2, 2, 1, 0, 32'h0000_0000, 0, 67, 1'b1, "R8/R10");
        run(3'd3, 3, 0, 0, 32'h0000_0200, 0, 65, 1'b0, "R3/R10");
        run(3'd0, 4, 2, 3, 32'h0000_0000, 2, 65, 1'b0, "R6/R10");
        run(3'd4, 0, 4, 0, 32'h0000_0200, 1, -1, 1'b0, "R4/R5");
        for (int i = 0; i < 64; i++)
            chk(mem[64 + i] == A_VAL * xv(i) + yv(i), "R12/R6 kernel result",
                mem[64 + i], A_VAL * xv(i) + yv(i));

        // Multiply result alone (R8).
        run(3'd4, 0, 2, 0, 32'h0000_0E00, 2, -1, 1'b0, "R4/R5");
        for (int i = 0; i < 64; i++)
            chk(mem[448 + i] == A_VAL * xv(i), "R8 low product", mem[448 + i], A_VAL * xv(i));

        // Vector-scalar add; scalar must be untouched by the refused poke (R2).
        run(3'd1, 5, 1, 0, 32'h0000_0000, 0, 65, 1'b0, "R7/R10");
        run(3'd4, 0, 5, 0, 32'h0000_0800, 0, 64, 1'b0, "R4");
        for (int i = 0; i < 64; i++)
            chk(mem[256 + i] == xv(i) + A_VAL, "R7/R2 scalar add", mem[256 + i], xv(i) + A_VAL);

        // Opcodes 6 and 7 have no effect (R11).
        run(3'd7, 5, 1, 1, 32'h0000_0C00, 0, 0, 1'b0, "R11");
        run(3'd6, 5, 4, 4, 32'h0000_0C00, 0, 0, 1'b0, "R11");
        run(3'd4, 0, 5, 0, 32'h0000_0A00, 2, -1, 1'b0, "R11/R5");
        for (int i = 0; i < 64; i++)
            chk(mem[320 + i] == xv(i) + A_VAL, "R11 register unchanged", mem[320 + i], xv(i) + A_VAL);

        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule